// File: doc/BRIEF.md
# Windowed Pixel Readout Address Sequencer

This block walks a rectangular window of a pixel array and emits one row/column address pair per readout slot, in raster order: columns form the inner loop and rows the outer loop. The window is set by a start and a size on each axis. Each axis can be reversed independently. Each axis can also use a 2x skip that reads two neighbouring lines and then passes over the next two. Two banks of skip enables are held side by side, and a select input picks which bank applies to a frame.

A reversed axis runs from start+size down to start+1 instead of from start up to start+size-1. This one-line shift keeps the colour of the first pixel in a 2x2 colour-filter tile unchanged. A frame begins when `run` is high while the sequencer is idle. Every setting is captured at that moment, so a frame never mixes old and new settings. If `run` is still high when the last address is issued, the next frame follows at once with freshly captured settings. A low-power setting limits readout to one address every second clock.

Top module: `win_addr_seq`

## Requirements
- R1: With column reversal off, the columns of each row are col_start, col_start+1, …, col_start+col_size-1, taken modulo 2^AW.
- R2: With column reversal on, the columns of each row are col_start+col_size, col_start+col_size-1, …, col_start+1, taken modulo 2^AW.
- R3: Rows follow the rule of R1 and R2, using row_start, row_size and mirror_row.
- R4: With skip on for an axis, offset k (0 ≤ k < size, counted from the first address in the traversal direction) is read only when k mod 4 is 0 or 1. This gives pairs such as 8, 9, 12, 13 going up, or the same pattern going down when reversed.
- R5: ctx_sel=0 applies skip_row_a/skip_col_a, and ctx_sel=1 applies skip_row_b/skip_col_b. The bank that is not selected has no effect on the addresses.
- R6: Addresses come out in raster order: every column of a row is issued before the row advances.
- R7: row_end is high exactly in the addr_valid cycles that carry the last column of a row, and low at all other times.
- R8: frame_end is high exactly in the addr_valid cycle that carries the last column of the last row.
- R9: Window, reversal, skip, bank select and low-power values are captured when a frame starts. Later changes to these inputs do not affect that frame.
- R10: In full-power mode, addr_valid stays high on consecutive cycles throughout a frame. In low-power mode, addr_valid is never high on two consecutive cycles, and this also holds across a frame boundary into or out of low power.
- R11: From idle, a high `run` produces the first address in the next cycle. At the last address of a frame, `run` high starts the next frame in the cycle that follows (or one cycle later if either frame is low power). `run` low returns the block to idle with addr_valid low.
- R12: While reset is asserted, addr_valid, row_end and frame_end are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start a frame when idle; continue into the next frame at frame end |
| row_start | input | AW | First row of the window |
| row_size | input | AW | Window height in rows (at least 1) |
| col_start | input | AW | First column of the window |
| col_size | input | AW | Window width in columns (at least 1) |
| mirror_row | input | 1 | Reverse row order |
| mirror_col | input | 1 | Reverse column order |
| skip_row_a | input | 1 | Row 2x skip, bank A |
| skip_col_a | input | 1 | Column 2x skip, bank A |
| skip_row_b | input | 1 | Row 2x skip, bank B |
| skip_col_b | input | 1 | Column 2x skip, bank B |
| ctx_sel | input | 1 | Bank select: 0 = A, 1 = B |
| low_power | input | 1 | Issue at most one address every two clocks |
| row_addr | output | AW | Current row address |
| col_addr | output | AW | Current column address |
| addr_valid | output | 1 | row_addr/col_addr hold a readout address |
| row_end | output | 1 | Last column of the current row |
| frame_end | output | 1 | Last address of the frame |

## Verification
The bench builds the block with AW=8 and uses window sizes of 1 to 12. Frames therefore stay short, and a start near 255 wraps the address arithmetic past zero, both going up and coming down. At this width the bench can run many random frames that mix reversal, skip, bank select and low power. It also runs directed frames that scramble every setting after the first address, and back-to-back frames that switch between full and low power.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  typedef struct packed {
    logic mir_row;
    logic mir_col;
    logic skip_row;
    logic skip_col;
    logic low_pwr;
  } wseq_mode_t;
endpackage

// File: rtl/wseq_cfg_latch.sv
module wseq_cfg_latch
  import wseq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] row_start,
  input  logic [AW-1:0] row_size,
  input  logic [AW-1:0] col_start,
  input  logic [AW-1:0] col_size,
  input  logic          mirror_row,
  input  logic          mirror_col,
  input  logic          skip_row_a,
  input  logic          skip_col_a,
  input  logic          skip_row_b,
  input  logic          skip_col_b,
  input  logic          ctx_sel,
  input  logic          low_power,
  output logic [AW-1:0] row_start_q,
  output logic [AW-1:0] row_size_q,
  output logic [AW-1:0] col_start_q,
  output logic [AW-1:0] col_size_q,
  output wseq_mode_t    mode_q
);
  wseq_mode_t mode_d;

  always_comb begin
    mode_d.mir_row  = mirror_row;
    mode_d.mir_col  = mirror_col;
    mode_d.skip_row = ctx_sel ? skip_row_b : skip_row_a;
    mode_d.skip_col = ctx_sel ? skip_col_b : skip_col_a;
    mode_d.low_pwr  = low_power;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_start_q <= '0;
      row_size_q  <= '0;
      col_start_q <= '0;
      col_size_q  <= '0;
      mode_q      <= '0;
    end else if (load) begin
      row_start_q <= row_start;
      row_size_q  <= row_size;
      col_start_q <= col_start;
      col_size_q  <= col_size;
      mode_q      <= mode_d;
    end
  end
endmodule

// File: rtl/wseq_axis.sv
module wseq_axis #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] size,
  input  logic          mirror,
  input  logic          skip,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam int KW = AW + 2;

  logic [KW-1:0] k_q, k_d, k_nxt;
  logic          k_en;
  logic [AW-1:0] k_lo;

  assign k_lo = k_q[AW-1:0];

  always_comb begin
    k_nxt = (skip && k_q[0]) ? k_q + KW'(3) : k_q + KW'(1);
    last  = (k_nxt >= KW'(size));
    addr  = mirror ? (start + size - k_lo) : (start + k_lo);
    k_en  = load | adv;
    if (load || last) k_d = '0;
    else              k_d = k_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    k_q <= '0;
    else if (k_en) k_q <= k_d;
  end
endmodule

// File: rtl/wseq_pacer.sv
module wseq_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic stop,
  input  logic lp_q,
  input  logic lp_in,
  output logic active,
  output logic valid
);
  logic act_q, act_d, ph_q, ph_d;

  always_comb begin
    act_d = act_q;
    if (load)      act_d = 1'b1;
    else if (stop) act_d = 1'b0;

    if (load)              ph_d = !(act_q && (lp_q || lp_in));
    else if (act_q && lp_q) ph_d = !ph_q;
    else                   ph_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 1'b1;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
    end
  end

  assign active = act_q;
  assign valid  = act_q & ph_q;
endmodule

// File: rtl/win_addr_seq.sv
module win_addr_seq
  import wseq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] row_start,
  input  logic [AW-1:0] row_size,
  input  logic [AW-1:0] col_start,
  input  logic [AW-1:0] col_size,
  input  logic          mirror_row,
  input  logic          mirror_col,
  input  logic          skip_row_a,
  input  logic          skip_col_a,
  input  logic          skip_row_b,
  input  logic          skip_col_b,
  input  logic          ctx_sel,
  input  logic          low_power,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic          addr_valid,
  output logic          row_end,
  output logic          frame_end
);
  logic [1:0]    rst_sync;
  logic          rst_i_n;
  logic [AW-1:0] row_start_q, row_size_q, col_start_q, col_size_q;
  wseq_mode_t    mode_q;
  logic          active, valid, load, stop;
  logic          col_last, row_last, frame_last, row_adv;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_comb begin
    frame_last = col_last & row_last;
    load       = run & (!active | (valid & frame_last));
    stop       = valid & frame_last & !run;
    row_adv    = valid & col_last;
  end

  wseq_cfg_latch #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .load(load),
    .row_start(row_start), .row_size(row_size),
    .col_start(col_start), .col_size(col_size),
    .mirror_row(mirror_row), .mirror_col(mirror_col),
    .skip_row_a(skip_row_a), .skip_col_a(skip_col_a),
    .skip_row_b(skip_row_b), .skip_col_b(skip_col_b),
    .ctx_sel(ctx_sel), .low_power(low_power),
    .row_start_q(row_start_q), .row_size_q(row_size_q),
    .col_start_q(col_start_q), .col_size_q(col_size_q),
    .mode_q(mode_q)
  );

  wseq_axis #(.AW(AW)) u_col (
    .clk(clk), .rst_n(rst_i_n), .load(load), .adv(valid),
    .start(col_start_q), .size(col_size_q),
    .mirror(mode_q.mir_col), .skip(mode_q.skip_col),
    .addr(col_addr), .last(col_last)
  );

  wseq_axis #(.AW(AW)) u_row (
    .clk(clk), .rst_n(rst_i_n), .load(load), .adv(row_adv),
    .start(row_start_q), .size(row_size_q),
    .mirror(mode_q.mir_row), .skip(mode_q.skip_row),
    .addr(row_addr), .last(row_last)
  );

  wseq_pacer u_pace (
    .clk(clk), .rst_n(rst_i_n), .load(load), .stop(stop),
    .lp_q(mode_q.low_pwr), .lp_in(low_power),
    .active(active), .valid(valid)
  );

  assign addr_valid = valid;
  assign row_end    = valid & col_last;
  assign frame_end  = valid & frame_last;
endmodule

// File: rtl/win_addr_seq_chk.sv
module win_addr_seq_chk
  import wseq_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid,
  input logic          row_end,
  input logic          frame_end,
  input wseq_mode_t    mode,
  input logic [AW-1:0] row_start_q,
  input logic [AW-1:0] col_start_q,
  input logic [AW-1:0] col
);
  // R7
  row_end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> valid);

  // R8
  frame_end_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> row_end);

  // R10
  lp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode.low_pwr) |=> !valid);

  // R10
  fp_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !frame_end && !mode.low_pwr) |=> valid);

  // R1
  col_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !row_end && !mode.low_pwr && !mode.mir_col && !mode.skip_col)
      |=> (col == AW'($past(col) + 1'b1)));

  // R2
  col_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !row_end && !mode.low_pwr && mode.mir_col && !mode.skip_col)
      |=> (col == AW'($past(col) - 1'b1)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !frame_end)
      |=> ($stable(mode) && $stable(row_start_q) && $stable(col_start_q)));
endmodule

bind win_addr_seq win_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .valid(addr_valid), .row_end(row_end),
  .frame_end(frame_end), .mode(mode_q), .row_start_q(row_start_q),
  .col_start_q(col_start_q), .col(col_addr)
);

// File: tb/win_addr_seq_bench.sv
module win_addr_seq_bench;
  localparam int AW = 8;

  typedef struct {
    int rs, rsz, cs, csz;
    bit mr, mc, sra, sca, srb, scb, ctx, lp;
  } cfg_t;

  logic clk, rst_n, run;
  logic [AW-1:0] row_start, row_size, col_start, col_size;
  logic mirror_row, mirror_col, skip_row_a, skip_col_a, skip_row_b, skip_col_b;
  logic ctx_sel, low_power;
  logic [AW-1:0] row_addr, col_addr;
  logic addr_valid, row_end, frame_end;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int erow [0:15];
  int ecol [0:15];
  int nr, nc;

  win_addr_seq #(.AW(AW)) u_win_addr_seq (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired: got %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input cfg_t c);
    row_start = AW'(c.rs); row_size = AW'(c.rsz);
    col_start = AW'(c.cs); col_size = AW'(c.csz);
    mirror_row = c.mr; mirror_col = c.mc;
    skip_row_a = c.sra; skip_col_a = c.sca;
    skip_row_b = c.srb; skip_col_b = c.scb;
    ctx_sel = c.ctx; low_power = c.lp;
  endtask

  function automatic cfg_t rnd_cfg();
    cfg_t c;
    c.rs = int'($urandom_range(255)); c.cs = int'($urandom_range(255));
    c.rsz = int'($urandom_range(12, 1)); c.csz = int'($urandom_range(12, 1));
    c.mr = 1'($urandom); c.mc = 1'($urandom);
    c.sra = 1'($urandom); c.sca = 1'($urandom);
    c.srb = 1'($urandom); c.scb = 1'($urandom);
    c.ctx = 1'($urandom); c.lp = 1'($urandom);
    return c;
  endfunction

  function automatic cfg_t mk(int rs, int rsz, int cs, int csz, bit mr, bit mc,
                              bit sra, bit sca, bit srb, bit scb, bit ctx, bit lp);
    cfg_t c;
    c.rs = rs; c.rsz = rsz; c.cs = cs; c.csz = csz; c.mr = mr; c.mc = mc;
    c.sra = sra; c.sca = sca; c.srb = srb; c.scb = scb; c.ctx = ctx; c.lp = lp;
    return c;
  endfunction

  // expected axis lists (R1..R5): offsets kept when k mod 4 < 2 under skip
  task automatic build(input cfg_t c);
    bit sr, sc;
    sr = c.ctx ? c.srb : c.sra;
    sc = c.ctx ? c.scb : c.sca;
    nr = 0; nc = 0;
    for (int k = 0; k < c.rsz; k++)
      if (!sr || (k % 4) < 2) begin
        erow[nr] = c.mr ? ((c.rs + c.rsz - k) & 255) : ((c.rs + k) & 255);
        nr++;
      end
    for (int k = 0; k < c.csz; k++)
      if (!sc || (k % 4) < 2) begin
        ecol[nc] = c.mc ? ((c.cs + c.csz - k) & 255) : ((c.cs + k) & 255);
        nc++;
      end
  endtask

  // Collect one frame. start_it raises run from idle; hold_run keeps run high
  // into the next frame; swap drives nxt on the first address; scramble
  // randomises every setting after each address (R9).
  task automatic run_frame(input cfg_t c, input string tag, input bit start_it,
                           input bit hold_run, input bit swap, input cfg_t nxt,
                           input bit scramble, input int exp_gap);
    int idx, total, gap, guard;
    bit prev_v;
    build(c);
    total = nr * nc;
    if (start_it) begin
      @(negedge clk);
      drive(c);
      run = 1'b1;
    end
    idx = 0; gap = 0; guard = 0; prev_v = 1'b0;
    while (idx < total && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (addr_valid) begin
        if (idx == 0) chk(gap == exp_gap, {tag, " R11 start gap"}, gap, exp_gap);
        // R6 raster order: row idx/nc, column idx%nc
        chk(int'(row_addr) == erow[idx / nc], {tag, " R3 row"}, int'(row_addr), erow[idx / nc]);
        chk(int'(col_addr) == ecol[idx % nc], {tag, " R1/R2/R4 col"}, int'(col_addr), ecol[idx % nc]);
        chk(row_end == ((idx % nc) == nc - 1), {tag, " R7 row_end"}, int'(row_end), int'((idx % nc) == nc - 1));
        chk(frame_end == (idx == total - 1), {tag, " R8 frame_end"}, int'(frame_end), int'(idx == total - 1));
        if (c.lp && prev_v) chk(1'b0, {tag, " R10 low-power back-to-back"}, 1, 0);
        if (idx == 0 && !hold_run) run = 1'b0;
        if (idx == 0 && swap) drive(nxt);
        if (scramble) drive(rnd_cfg());
        idx++;
      end else begin
        if (idx > 0 && !c.lp) chk(1'b0, {tag, " R10 full-power gap"}, 0, 1);
        if (idx == 0) gap++;
        chk(!row_end && !frame_end, {tag, " R7 flags idle"}, int'({row_end, frame_end}), 0);
      end
      prev_v = addr_valid;
    end
    chk(idx == total, {tag, " R11 frame completed"}, idx, total);
    if (!hold_run) begin
      repeat (3) begin
        @(negedge clk);
        chk(!addr_valid, {tag, " R11 idle after frame"}, int'(addr_valid), 0);
      end
    end
  endtask

  initial begin
    cfg_t a, b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; run = 1'b0;
    drive(mk(0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!addr_valid, "R12 valid in reset", int'(addr_valid), 0);
    chk(!row_end, "R12 row_end in reset", int'(row_end), 0);
    chk(!frame_end, "R12 frame_end in reset", int'(frame_end), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!addr_valid, "R11 idle without run", int'(addr_valid), 0);

    a = mk(10, 4, 20, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    run_frame(a, "R1 plain", 1, 0, 0, a, 0, 0);
    a = mk(10, 4, 20, 5, 0, 1, 0, 0, 0, 0, 0, 0);
    run_frame(a, "R2 col mirror", 1, 0, 0, a, 0, 0);
    a = mk(8, 6, 3, 3, 1, 0, 0, 0, 0, 0, 0, 0);
    run_frame(a, "R3 row mirror", 1, 0, 0, a, 0, 0);
    a = mk(8, 8, 0, 3, 0, 0, 1, 0, 0, 1, 0, 0);
    run_frame(a, "R4 R5 row skip bank A", 1, 0, 0, a, 0, 0);
    a = mk(8, 3, 0, 10, 0, 0, 1, 0, 0, 1, 1, 0);
    run_frame(a, "R5 col skip bank B", 1, 0, 0, a, 0, 0);
    a = mk(4, 9, 30, 11, 1, 1, 1, 1, 0, 0, 0, 0);
    run_frame(a, "R4 skip mirror", 1, 0, 0, a, 0, 0);
    a = mk(250, 10, 251, 7, 0, 1, 0, 0, 0, 0, 0, 1);
    run_frame(a, "R10 low power wrap", 1, 0, 0, a, 0, 0);
    a = mk(5, 1, 6, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    run_frame(a, "R8 single pixel", 1, 0, 0, a, 0, 0);
    a = mk(2, 5, 7, 6, 0, 1, 0, 1, 1, 0, 0, 0);
    run_frame(a, "R9 scramble", 1, 0, 0, a, 1, 0);
    a = mk(1, 3, 2, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    b = mk(40, 2, 50, 5, 1, 0, 0, 0, 0, 1, 1, 1);
    run_frame(a, "R11 chain A", 1, 1, 1, b, 0, 0);
    run_frame(b, "R11 chain B", 0, 0, 0, b, 0, 1);
    a = mk(9, 2, 9, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    b = mk(3, 3, 4, 3, 0, 1, 1, 1, 1, 1, 1, 0);
    run_frame(a, "R11 chain fp A", 1, 1, 1, b, 0, 0);
    run_frame(b, "R11 chain fp B", 0, 0, 0, b, 0, 0);

    for (int i = 0; i < 40; i++) begin
      a = rnd_cfg();
      run_frame(a, "R6 random", 1, 0, 0, a, (i % 5) == 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule